// File: doc/BRIEF.md
# Lock-Aware Fully Associative Address Translation Buffer

This block is a small associative cache of address translations for a 32-bit machine with 4 KiB pages. Each slot holds a 20-bit virtual page tag, a 20-bit physical frame, a 4-bit rights nibble and a lock flag. A lookup gives a virtual address and an access kind (read, write or execute). In the same cycle the block returns either the physical address or a fault with a 4-bit cause. The faulting address is reported along with the cause.

A separate insert port writes a complete slot on the next clock edge. If the tag is already present, that slot is rewritten. Otherwise an empty slot is used, or the oldest unlocked slot. A global enable turns translation off, and addresses then pass through unchanged. Filling slots from in-memory tables and handling the trap are done outside the block.

Both ports carry a valid strobe only. The block never applies back-pressure: a lookup is answered in the cycle it is presented, and an insert is always accepted or explicitly rejected. The caller therefore needs no ready signal and may issue one request on each port in every cycle.

Top module: `xlat_tlb`

## Requirements
- R1: After reset every slot is empty, so each enabled lookup faults with cause 0000, and `ins_err` is low.
- R2: An enabled, valid lookup that matches a slot and passes the rights check drives `lk_paddr` = {frame, vaddr[11:0]} with `lk_fault` low.
- R3: An enabled, valid lookup that matches no slot raises `lk_fault` with cause 0000 and puts the virtual address on `lk_fault_vaddr`. `lk_fault_vaddr` is zero whenever `lk_fault` is low.
- R4: Rights and cause share one layout: bit 3 valid, bit 2 readable, bit 1 writable, bit 0 executable. Access codes are 0 read, 1 write, 2 or 3 execute. On a tag match, exactly one cause bit is set, checked in this order: bit 3 if the slot is not valid; else bit 2 for a read of a non-readable page; else bit 1 for a write of a non-writable page; else bit 0 for an execute of a non-executable page. `lk_paddr` is zero on a fault.
- R5: With `en` low, `lk_paddr` equals `lk_vaddr`, no fault is raised, and no slot's age changes.
- R6: An insert whose tag is already present rewrites that slot in place, including its rights, frame and lock flag.
- R7: An insert of a new tag uses the lowest-indexed empty slot. If no slot is empty, it replaces the unlocked slot with the largest age, and the lowest index wins a tie.
- R8: A slot with its lock flag set is never replaced by an insert of a different tag.
- R9: An insert of a new tag when every slot is occupied and locked is dropped, and `ins_err` is high for the one following cycle.
- R10: An insert takes effect at the next clock edge. A lookup in the same cycle sees the old contents.
- R11: Each slot has a 3-bit age that saturates at 7. In a cycle with any touch, each touched slot's age goes to 0 and every other slot's age rises by one. A touch is a lookup tag match while enabled, or an accepted insert.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Translation enable; low passes addresses through |
| lk_valid | input | 1 | Lookup request strobe |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_op | input | 2 | Access kind: 0 read, 1 write, 2/3 execute |
| lk_paddr | output | 32 | Translated (or passed-through) address |
| lk_fault | output | 1 | Lookup fault |
| lk_cause | output | 4 | Fault cause, rights layout, 0000 on a miss |
| lk_fault_vaddr | output | 32 | Faulting virtual address, zero when no fault |
| ins_valid | input | 1 | Insert request strobe |
| ins_vpn | input | 20 | Page tag to insert |
| ins_rights | input | 4 | Rights nibble to store |
| ins_lock | input | 1 | Lock flag to store |
| ins_frame | input | 20 | Physical frame to store |
| ins_err | output | 1 | Pulses the cycle after a dropped insert |

## Verification
A lookup and an insert can fall in the same cycle. This matters most when both name the same page, or when the lookup refreshes a slot that would otherwise be the victim. The bench provokes this with directed cycles that look up a page while it is being inserted, and with random traffic that issues both requests together over a small pool of tags. The outcome is judged against a bench model that applies the pre-edge contents to the lookup and applies both touches to the ages at the edge.

// File: rtl/xlat_tlb_pkg.sv
package xlat_tlb_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_EXEC2 = 2'd3
  } acc_e;

  localparam int RB_V = 3;
  localparam int RB_R = 2;
  localparam int RB_W = 1;
  localparam int RB_X = 0;

  function automatic logic [3:0] rights_cause(input logic [3:0] rights, input acc_e acc);
    logic [3:0] c;
    c = 4'b0000;
    if (!rights[RB_V])                         c[RB_V] = 1'b1;
    else if (acc == ACC_READ  && !rights[RB_R]) c[RB_R] = 1'b1;
    else if (acc == ACC_WRITE && !rights[RB_W]) c[RB_W] = 1'b1;
    else if (acc[1]           && !rights[RB_X]) c[RB_X] = 1'b1;
    return c;
  endfunction
endpackage

// File: rtl/xlat_tlb_cam.sv
module xlat_tlb_cam #(
  parameter int N     = 8,
  parameter int TAG_W = 20,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]            present,
  input  logic [N-1:0][TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]        key,
  output logic                    hit,
  output logic [IDX_W-1:0]        idx
);
  logic [N-1:0] match;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = present[g] && (tags[g] == key);
  end

  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (match[i] && !hit) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/xlat_tlb_victim.sv
module xlat_tlb_victim #(
  parameter int N     = 8,
  parameter int AGE_W = 3,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]            present,
  input  logic [N-1:0]            locked,
  input  logic [N-1:0][AGE_W-1:0] ages,
  output logic [IDX_W-1:0]        victim,
  output logic                    none_free
);
  logic             have_empty, have_old;
  logic [IDX_W-1:0] empty_idx, old_idx;
  logic [AGE_W-1:0] best;

  always_comb begin
    have_empty = 1'b0;
    empty_idx  = '0;
    have_old   = 1'b0;
    old_idx    = '0;
    best       = '0;
    for (int i = 0; i < N; i++) begin
      if (!present[i] && !have_empty) begin
        have_empty = 1'b1;
        empty_idx  = IDX_W'(i);
      end
    end
    for (int i = 0; i < N; i++) begin
      if (present[i] && !locked[i] && (!have_old || ages[i] > best)) begin
        have_old = 1'b1;
        best     = ages[i];
        old_idx  = IDX_W'(i);
      end
    end
    victim    = have_empty ? empty_idx : old_idx;
    none_free = !have_empty && !have_old;
  end
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
  import xlat_tlb_pkg::*;
#(
  parameter int N     = 8,
  parameter int VPN_W = 20,
  parameter int PFN_W = 20,
  parameter int OFF_W = 12,
  parameter int AGE_W = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic                     lk_valid,
  input  logic [VPN_W+OFF_W-1:0]   lk_vaddr,
  input  logic [1:0]               lk_op,
  output logic [PFN_W+OFF_W-1:0]   lk_paddr,
  output logic                     lk_fault,
  output logic [3:0]               lk_cause,
  output logic [VPN_W+OFF_W-1:0]   lk_fault_vaddr,
  input  logic                     ins_valid,
  input  logic [VPN_W-1:0]         ins_vpn,
  input  logic [3:0]               ins_rights,
  input  logic                     ins_lock,
  input  logic [PFN_W-1:0]         ins_frame,
  output logic                     ins_err
);
  localparam int IDX_W = $clog2(N);
  localparam int VA_W  = VPN_W + OFF_W;
  localparam int PA_W  = PFN_W + OFF_W;
  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  logic [N-1:0]            present, locked;
  logic [N-1:0][VPN_W-1:0] tags;
  logic [N-1:0][3:0]       rights;
  logic [N-1:0][PFN_W-1:0] frames;
  logic [N-1:0][AGE_W-1:0] ages;

  logic             lk_hit, ins_hit, none_free, wr_en, lk_touch;
  logic [IDX_W-1:0] lk_idx, ins_idx, vic_idx, wr_idx;
  logic [3:0]       cause;
  logic [N-1:0]     touch;

  xlat_tlb_cam #(.N(N), .TAG_W(VPN_W), .IDX_W(IDX_W)) u_lk_cam (
    .present(present), .tags(tags), .key(lk_vaddr[VA_W-1:OFF_W]),
    .hit(lk_hit), .idx(lk_idx));

  xlat_tlb_cam #(.N(N), .TAG_W(VPN_W), .IDX_W(IDX_W)) u_ins_cam (
    .present(present), .tags(tags), .key(ins_vpn),
    .hit(ins_hit), .idx(ins_idx));

  xlat_tlb_victim #(.N(N), .AGE_W(AGE_W), .IDX_W(IDX_W)) u_victim (
    .present(present), .locked(locked), .ages(ages),
    .victim(vic_idx), .none_free(none_free));

  always_comb begin
    cause          = lk_hit ? rights_cause(rights[lk_idx], acc_e'(lk_op)) : 4'b0000;
    lk_fault       = 1'b0;
    lk_cause       = 4'b0000;
    lk_paddr       = '0;
    lk_fault_vaddr = '0;
    if (!en) begin
      lk_paddr = PA_W'(lk_vaddr);
    end else if (lk_valid) begin
      if (lk_hit && cause == 4'b0000) begin
        lk_paddr = {frames[lk_idx], lk_vaddr[OFF_W-1:0]};
      end else begin
        lk_fault       = 1'b1;
        lk_cause       = cause;
        lk_fault_vaddr = lk_vaddr;
      end
    end
  end

  assign lk_touch = en && lk_valid && lk_hit;
  assign wr_en    = ins_valid && (ins_hit || !none_free);
  assign wr_idx   = ins_hit ? ins_idx : vic_idx;

  for (genvar g = 0; g < N; g++) begin : g_touch
    assign touch[g] = (wr_en && wr_idx == IDX_W'(g)) || (lk_touch && lk_idx == IDX_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      present <= '0;
      locked  <= '0;
      tags    <= '0;
      rights  <= '0;
      frames  <= '0;
      ages    <= {N{AGE_MAX}};
      ins_err <= 1'b0;
    end else begin
      ins_err <= ins_valid && !ins_hit && none_free;
      for (int i = 0; i < N; i++) begin
        if (touch[i])
          ages[i] <= '0;
        else if (|touch && ages[i] != AGE_MAX)
          ages[i] <= ages[i] + 1'b1;
        if (wr_en && wr_idx == IDX_W'(i)) begin
          present[i] <= 1'b1;
          locked[i]  <= ins_lock;
          tags[i]    <= ins_vpn;
          rights[i]  <= ins_rights;
          frames[i]  <= ins_frame;
        end
      end
    end
  end
endmodule

// File: rtl/xlat_tlb_chk.sv
module xlat_tlb_chk #(
  parameter int N     = 8,
  parameter int VPN_W = 20,
  parameter int PFN_W = 20,
  parameter int OFF_W = 12
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     en,
  input logic                     lk_valid,
  input logic [VPN_W+OFF_W-1:0]   lk_vaddr,
  input logic [PFN_W+OFF_W-1:0]   lk_paddr,
  input logic                     lk_fault,
  input logic [3:0]               lk_cause,
  input logic [VPN_W+OFF_W-1:0]   lk_fault_vaddr,
  input logic                     ins_valid,
  input logic                     ins_err,
  input logic [N-1:0]             present,
  input logic [N-1:0]             locked,
  input logic [N-1:0][VPN_W-1:0]  tags
);
  AST_CAUSE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fault |-> $onehot0(lk_cause)); // R4

  AST_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (lk_paddr == lk_vaddr && !lk_fault)); // R5

  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (en && lk_valid && !lk_fault) |-> lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]); // R2

  AST_FAULT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fault |-> (lk_fault_vaddr == lk_vaddr && en && lk_valid)); // R3

  AST_ERR_AFTER_INSERT: assert property (@(posedge clk) disable iff (!rst_n)
    ins_err |-> $past(ins_valid)); // R9

  for (genvar g = 0; g < N; g++) begin : g_lock
    AST_LOCK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (present[g] && locked[g]) |=> (present[g] && tags[g] == $past(tags[g]))); // R8
  end
endmodule

bind xlat_tlb xlat_tlb_chk #(.N(N), .VPN_W(VPN_W), .PFN_W(PFN_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
  .lk_paddr(lk_paddr), .lk_fault(lk_fault), .lk_cause(lk_cause),
  .lk_fault_vaddr(lk_fault_vaddr), .ins_valid(ins_valid), .ins_err(ins_err),
  .present(present), .locked(locked), .tags(tags));

// File: tb/xlat_tlb_test.sv
`timescale 1ns/1ps
module xlat_tlb_test;
  logic        clk = 0, rst_n = 0;
  logic        en = 0, lk_valid = 0, ins_valid = 0, ins_lock = 0;
  logic [31:0] lk_vaddr = 0;
  logic [1:0]  lk_op = 0;
  logic [19:0] ins_vpn = 0, ins_frame = 0;
  logic [3:0]  ins_rights = 0;
  logic [31:0] lk_paddr, lk_fault_vaddr;
  logic        lk_fault, ins_err;
  logic [3:0]  lk_cause;

  always #10 clk = ~clk;

  xlat_tlb uut (.*);

  int vectors = 0, errors = 0;
  bit done = 0;

  // bench model
  bit        m_pres[8], m_lock[8];
  bit [19:0] m_tag[8], m_frame[8];
  bit [3:0]  m_rt[8];
  int        m_age[8];
  bit        m_err;
  bit        last_fault;
  bit [3:0]  last_cause;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int m_find(input bit [19:0] t);
    for (int i = 0; i < 8; i++) if (m_pres[i] && m_tag[i] == t) return i;
    return -1;
  endfunction

  function automatic int m_victim();
    int b = -1;
    for (int i = 0; i < 8; i++) if (!m_pres[i]) return i;
    for (int i = 0; i < 8; i++)
      if (!m_lock[i] && (b < 0 || m_age[i] > m_age[b])) b = i;
    return b;
  endfunction

  function automatic bit [3:0] m_cause(input bit [3:0] r, input bit [1:0] op);
    if (!r[3]) return 4'b1000;
    if (op == 0 && !r[2]) return 4'b0100;
    if (op == 1 && !r[1]) return 4'b0010;
    if (op[1] && !r[0]) return 4'b0001;
    return 4'b0000;
  endfunction

  task automatic do_reset();
    rst_n = 0; en = 0; lk_valid = 0; ins_valid = 0;
    for (int i = 0; i < 8; i++) begin m_pres[i] = 0; m_lock[i] = 0; m_age[i] = 7; end
    m_err = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic step(input bit e, input bit lv, input bit [31:0] va, input bit [1:0] op,
                      input bit iv, input bit [19:0] iv_vpn, input bit [3:0] ir,
                      input bit il, input bit [19:0] ifr);
    int h, wi;
    bit [3:0] c;
    bit touch[8];
    bit any;
    @(negedge clk);
    en = e; lk_valid = lv; lk_vaddr = va; lk_op = op;
    ins_valid = iv; ins_vpn = iv_vpn; ins_rights = ir; ins_lock = il; ins_frame = ifr;
    #1;
    last_fault = lk_fault; last_cause = lk_cause;
    check(ins_err == m_err, "R9 ins_err", ins_err, m_err);
    h = m_find(va[31:12]);
    if (!e) begin
      check(lk_paddr == va && !lk_fault, "R5 bypass", {lk_fault, lk_paddr}, {1'b0, va});
    end else if (lv) begin
      if (h < 0) begin
        check(lk_fault && lk_cause == 0 && lk_fault_vaddr == va, "R3 miss",
              {lk_fault, lk_cause, lk_fault_vaddr}, {1'b1, 4'b0, va});
      end else begin
        c = m_cause(m_rt[h], op);
        if (c == 0)
          check(!lk_fault && lk_paddr == {m_frame[h], va[11:0]}, "R2 hit",
                {lk_fault, lk_paddr}, {1'b0, m_frame[h], va[11:0]});
        else
          check(lk_fault && lk_cause == c && lk_paddr == 0 && lk_fault_vaddr == va, "R4 cause",
                {lk_fault, lk_cause, lk_paddr}, {1'b1, c, 32'h0});
      end
    end
    // next-state of model
    for (int i = 0; i < 8; i++) touch[i] = 0;
    if (e && lv && h >= 0) touch[h] = 1;
    wi = -1;
    if (iv) begin
      wi = m_find(iv_vpn);
      if (wi < 0) wi = m_victim();
    end
    if (wi >= 0) touch[wi] = 1;
    @(posedge clk);
    any = 0;
    for (int i = 0; i < 8; i++) any |= touch[i];
    for (int i = 0; i < 8; i++)
      if (touch[i]) m_age[i] = 0; else if (any && m_age[i] < 7) m_age[i]++;
    m_err = iv && (wi < 0);
    if (wi >= 0) begin
      m_pres[wi] = 1; m_lock[wi] = il; m_tag[wi] = iv_vpn; m_rt[wi] = ir; m_frame[wi] = ifr;
    end
  endtask

  task automatic ins(input bit [19:0] v, input bit [3:0] r, input bit l, input bit [19:0] f);
    step(1, 0, 0, 0, 1, v, r, l, f);
  endtask

  task automatic look(input bit [31:0] va, input bit [1:0] op);
    step(1, 1, va, op, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    do_reset();
    // R1: empty after reset
    look(32'h0000_5123, 0);
    check(last_fault && last_cause == 0, "R1 reset miss", {last_fault, last_cause}, 5'h10);
    check(ins_err == 0, "R1 err low", ins_err, 0);
    // R10: insert and lookup same page in one cycle -> old contents
    step(1, 1, 32'h0000_1abc, 0, 1, 20'h1, 4'hF, 0, 20'hAAAA1);
    check(last_fault && last_cause == 0, "R10 same-cycle sees old", {last_fault, last_cause}, 5'h10);
    look(32'h0000_1abc, 0);
    check(!last_fault, "R10 visible next cycle", last_fault, 0);
    // R4 priority: invalid beats everything, read/write/exec singles
    ins(20'h2, 4'b0000, 0, 20'h2);
    look(32'h0000_2000, 1);
    ins(20'h3, 4'b1010, 0, 20'h3);
    look(32'h0000_3004, 0); look(32'h0000_3004, 1); look(32'h0000_3004, 2); look(32'h0000_3004, 3);
    // R6: overwrite in place
    ins(20'h3, 4'b1111, 0, 20'h33333);
    look(32'h0000_3fff, 2);
    check(!last_fault, "R6 overwrite rights", last_fault, 0);
    // R7/R11: fill remaining slots, touch some, insert new
    for (int i = 4; i < 9; i++) ins(20'(i), 4'hF, 0, 20'(i + 'h100));
    look(32'h0000_1000, 0); look(32'h0000_2000, 0);
    ins(20'h40, 4'hF, 0, 20'h40);
    look(32'h0000_3000, 0);
    check(last_fault && last_cause == 0, "R7 oldest evicted", {last_fault, last_cause}, 5'h10);
    // R8/R9: lock everything then insert new tag
    for (int i = 0; i < 8; i++) ins(m_tag[i], 4'hF, 1, 20'(i));
    ins(20'h77, 4'hF, 0, 20'h77);
    look(32'h0000_0000, 0);
    check(ins_err == 0 || 1, "R9 pulse checked in step", 0, 0);
    look(32'h0000_4000, 0);
    check(!last_fault, "R8 locked slot kept", last_fault, 0);
    // R5 disabled lookup
    step(0, 1, 32'hDEAD_BEEF, 1, 0, 0, 0, 0, 0);
    // random mix with lookups and inserts together
    do_reset();
    for (int n = 0; n < 4000; n++) begin
      bit [19:0] pv = 20'($urandom_range(0, 13));
      step($urandom_range(0, 9) != 0, $urandom_range(0, 3) != 0,
           {20'($urandom_range(0, 13)), 12'($urandom)}, 2'($urandom),
           $urandom_range(0, 2) == 0, pv, 4'($urandom) | 4'b1000 & {4{$urandom_range(0,5)!=0}},
           $urandom_range(0, 11) == 0, 20'($urandom));
      if (n % 1000 == 999) do_reset();
    end
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule